// File: doc/BRIEF.md
# Dual-Queue Conversion Command Scheduler

This block decides which entry of a shared command table the converter runs next. The table holds two queues. Queue 1 has high priority and always begins at entry 0. Queue 2 has low priority and begins at a start index supplied on an input. Queue 1 ends at that index. The block drives the table read address, which is also the command word pointer. It reads the addressed 16-bit command word back in the same cycle. For each command it runs, it gives the converter a one-cycle start pulse and a channel number, then waits for a conversion-done pulse before it moves on.

Each queue is started by its own trigger pulse. A command word may carry a pause flag, which stops its queue after that command until the queue is triggered again. A queue 1 trigger takes the converter away from a running queue 2. Queue 2 is parked as suspended and later resumes at the command that was cut short. A queue 2 trigger that arrives while queue 1 is running or paused is held as pending. A scan ends on a reserved channel code, on the queue 2 start index (queue 1 only), or after the read that follows a wrap past the last table entry. The block then raises a one-cycle completion flag for the queue that ended.

Top module: `dq_cmd_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, both queues go idle, `cwp` becomes 0, and `conv_start`, both completion flags and both pause flags are low.
- R2: For every command it runs, the block raises `conv_start` for exactly one cycle. `conv_chan` equals bits 5:0 of the command word at `cwp`. Bits 14:6 of the command word have no effect. Each `conv_done` received for the running command advances `cwp` by one, and the next command starts only after that.
- R3: A `q1_trig` pulse while queue 1 is idle runs queue 1 from entry 0. Queue 1 ends when `cwp` reaches `q2_start`. At that point `q1_done` is high for one cycle, queue 1 is idle, and `cwp` stays equal to `q2_start`.
- R4: A command word whose channel field is 63 is an end-of-queue marker. It is never sent to the converter. The scan ends with that queue's completion flag, and `cwp` stays on the marker entry.
- R5: A `q2_trig` pulse while both queues are idle runs queue 2 from `q2_start`. If entry 63 is converted without meeting a marker, `cwp` wraps to 0. The scan then ends on that read, with `q2_done` high and `cwp` equal to 0.
- R6: A command with bit 15 set is converted first. Its queue then becomes paused, raises its pause flag for one cycle, and leaves `cwp` on the following entry. A later trigger of that queue continues from that entry.
- R7: A `q1_trig` pulse while queue 2 is active suspends queue 2 and runs queue 1 from entry 0. When queue 1 completes, queue 2 resumes at the entry whose conversion was cut short, which is converted again.
- R8: A `q2_trig` pulse while queue 1 is active or paused makes queue 2 pending. Queue 2 then starts, at `q2_start` if it was idle or at its paused entry if it was paused, in the cycle queue 1 completes.
- R9: A trigger for a queue that is already active (or, for queue 2, suspended or pending) has no effect on the commands converted or on `cwp`.
- R10: `q1_status` encodes idle=0, active=1, paused=2. `q2_status` encodes idle=0, active=1, paused=2, suspended=3, pending=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q1_trig | input | 1 | Queue 1 trigger event, one-cycle pulse |
| q2_trig | input | 1 | Queue 2 trigger event, one-cycle pulse |
| q2_start | input | 6 | First table entry of queue 2; also the end of queue 1 |
| cmd_word | input | 16 | Command word read from the table at `cwp` |
| conv_done | input | 1 | Conversion-done pulse from the converter |
| cwp | output | 6 | Command word pointer and table read address |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 6 | Channel for the conversion being started |
| q1_done | output | 1 | Queue 1 scan completed, one cycle |
| q2_done | output | 1 | Queue 2 scan completed, one cycle |
| q1_paused | output | 1 | Queue 1 entered the paused state, one cycle |
| q2_paused | output | 1 | Queue 2 entered the paused state, one cycle |
| q1_status | output | 2 | Queue 1 state code |
| q2_status | output | 3 | Queue 2 state code |

## Verification
The bench builds the block with its default parameters: a 64-entry table, 6-bit channels and the pause flag in bit 15. At this size the reserved channel code 63 and the wrap from entry 63 back to entry 0 can both be reached, so the marker and wrap endings are tested on the real table boundary. The queue 2 start index, the converter latency and the table contents are drawn at random. This varies the queue 1 length, including empty queues, from run to run. Directed runs place a preemption inside a conversion that is still in flight, and a queue 2 trigger during both an active and a paused queue 1.

// File: rtl/dq_sched_pkg.sv
// Package: state encodings shared by the scheduler modules.
// Assumes: codes are visible at the top-level status ports, so they are fixed.
package dq_sched_pkg;

    typedef enum logic [1:0] {
        HQ_IDLE   = 2'd0,
        HQ_ACTIVE = 2'd1,
        HQ_PAUSED = 2'd2
    } hq_state_e;

    typedef enum logic [2:0] {
        LQ_IDLE    = 3'd0,
        LQ_ACTIVE  = 3'd1,
        LQ_PAUSED  = 3'd2,
        LQ_SUSPEND = 3'd3,
        LQ_PENDING = 3'd4
    } lq_state_e;

endpackage

// File: rtl/dq_cmd_decode.sv
// Module: dq_cmd_decode
// Splits the command word read at the pointer into channel and pause flag,
// and decides whether the running queue has reached its end at this entry.
// Assumes: the table read is combinational (word belongs to the current cwp).
module dq_cmd_decode #(
    parameter int CMD_W     = 16,
    parameter int CHAN_W    = 6,
    parameter int PAUSE_BIT = 15,
    parameter int IDX_W     = 6
) (
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [IDX_W-1:0]  cwp,
    input  logic [IDX_W-1:0]  q2_start,
    input  logic              owner_hi,
    input  logic              wrapped,
    output logic [CHAN_W-1:0] chan,
    output logic              pause,
    output logic              end_cond
);
    localparam logic [CHAN_W-1:0] EOQ_CODE = '1;

    logic unused_fields;
    logic hit_marker;
    logic hit_boundary;

    // Field extraction; the bits between channel and pause flag are don't-care.
    always_comb begin
        chan          = cmd_word[CHAN_W-1:0];
        pause         = cmd_word[PAUSE_BIT];
        unused_fields = ^cmd_word[PAUSE_BIT-1:CHAN_W];
    end

    // End-of-queue: reserved code, queue 1 reaching queue 2, or post-wrap read.
    always_comb begin
        hit_marker   = (chan == EOQ_CODE);
        hit_boundary = owner_hi && (cwp == q2_start);
        end_cond     = hit_marker || hit_boundary || wrapped;
    end

endmodule

// File: rtl/dq_conv_port.sv
// Module: dq_conv_port
// Converter handshake: issues a one-cycle start with the channel, holds a busy
// flag until conversion-done, and remembers the pause flag of the command.
// Assumes: a new start restarts the converter, so an aborted conversion's
// done pulse never arrives after the abort.
module dq_conv_port #(
    parameter int CHAN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              abort,
    input  logic              conv_done,
    input  logic [CHAN_W-1:0] new_chan,
    input  logic              new_pause,
    output logic              busy,
    output logic              done_evt,
    output logic              cur_pause,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan
);

    // Only a done pulse that answers an outstanding command counts.
    assign done_evt = conv_done && busy;

    // Start pulse, channel latch and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cur_pause  <= 1'b0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= issue;
            if (issue) begin
                busy      <= 1'b1;
                conv_chan <= new_chan;
                cur_pause <= new_pause;
            end else if (abort || done_evt) begin
                busy <= 1'b0;
            end
        end
    end

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

endmodule

// File: rtl/dq_queue_ctrl.sv
// Module: dq_queue_ctrl
// Holds both queue states, the command word pointer and the resume points.
// Each cycle it applies, in order: the engine event (end or conversion done),
// queue 2 resumption on queue 1 completion, a queue 1 trigger, a queue 2 trigger.
// Assumes: q2_start is stable while a scan runs; table depth is a power of two.
module dq_queue_ctrl
    import dq_sched_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q1_trig,
    input  logic             q2_trig,
    input  logic [IDX_W-1:0] q2_start,
    input  logic             end_cond,
    input  logic             busy,
    input  logic             done_evt,
    input  logic             cur_pause,
    output logic [IDX_W-1:0] cwp,
    output hq_state_e        hq_st,
    output lq_state_e        lq_st,
    output logic             owner_hi,
    output logic             wrapped,
    output logic             issue,
    output logic             abort,
    output logic             q1_done,
    output logic             q2_done,
    output logic             q1_paused,
    output logic             q2_paused
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    logic             run_hi, run_lo, run_any, end_hit;
    logic [IDX_W-1:0] adv;
    logic [IDX_W-1:0] hq_ptr, lq_ptr;
    logic             lq_wrap;

    hq_state_e        hq_n;
    lq_state_e        lq_n;
    logic [IDX_W-1:0] cwp_n, hq_ptr_n, lq_ptr_n, lo_ptr_sel;
    logic             wrap_n, lq_wrap_n, lo_wrap_sel;
    logic             q1_done_n, q2_done_n, q1_pz_n, q2_pz_n;

    // Owner selection: queue 1 has priority over queue 2.
    always_comb begin
        run_hi   = (hq_st == HQ_ACTIVE);
        run_lo   = (lq_st == LQ_ACTIVE) && !run_hi;
        run_any  = run_hi || run_lo;
        owner_hi = run_hi;
        end_hit  = run_any && !busy && end_cond;
        adv      = (cwp == LAST_IDX) ? '0 : cwp + 1'b1;
        issue    = run_any && !busy && !end_cond && !(q1_trig && hq_st != HQ_ACTIVE);
    end

    // Next-state evaluation in priority order.
    always_comb begin
        hq_n = hq_st;       lq_n = lq_st;
        cwp_n = cwp;        wrap_n = wrapped;
        hq_ptr_n = hq_ptr;  lq_ptr_n = lq_ptr;  lq_wrap_n = lq_wrap;
        q1_done_n = 1'b0;   q2_done_n = 1'b0;
        q1_pz_n = 1'b0;     q2_pz_n = 1'b0;
        abort = 1'b0;
        lo_ptr_sel = lq_ptr; lo_wrap_sel = lq_wrap;

        if (end_hit) begin
            if (run_hi) begin hq_n = HQ_IDLE; q1_done_n = 1'b1; end
            else        begin lq_n = LQ_IDLE; q2_done_n = 1'b1; end
        end else if (done_evt) begin
            cwp_n  = adv;
            wrap_n = wrapped || (cwp == LAST_IDX);
            if (cur_pause) begin
                if (run_hi) begin
                    hq_n = HQ_PAUSED; hq_ptr_n = adv; q1_pz_n = 1'b1;
                end else begin
                    lq_n = LQ_PAUSED; lq_ptr_n = adv; lq_wrap_n = wrap_n; q2_pz_n = 1'b1;
                end
            end
        end

        if (end_hit && run_hi && (lq_n == LQ_SUSPEND || lq_n == LQ_PENDING)) begin
            lq_n = LQ_ACTIVE; cwp_n = lq_ptr_n; wrap_n = lq_wrap_n;
        end

        if (q1_trig && hq_n != HQ_ACTIVE) begin
            abort = 1'b1;
            if (lq_n == LQ_ACTIVE) begin
                lq_n = LQ_SUSPEND; lq_ptr_n = cwp_n; lq_wrap_n = wrap_n;
            end
            cwp_n  = (hq_n == HQ_IDLE) ? '0 : hq_ptr_n;
            wrap_n = 1'b0;
            hq_n   = HQ_ACTIVE;
        end

        if (q2_trig && (lq_n == LQ_IDLE || lq_n == LQ_PAUSED)) begin
            lo_ptr_sel  = (lq_n == LQ_IDLE) ? q2_start : lq_ptr_n;
            lo_wrap_sel = (lq_n == LQ_IDLE) ? 1'b0 : lq_wrap_n;
            lq_ptr_n    = lo_ptr_sel;
            lq_wrap_n   = lo_wrap_sel;
            if (hq_n != HQ_IDLE) begin
                lq_n = LQ_PENDING;
            end else begin
                lq_n = LQ_ACTIVE; cwp_n = lo_ptr_sel; wrap_n = lo_wrap_sel;
            end
        end
    end

    // State, pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hq_st <= HQ_IDLE;  lq_st <= LQ_IDLE;
            cwp <= '0;         wrapped <= 1'b0;
            hq_ptr <= '0;      lq_ptr <= '0;     lq_wrap <= 1'b0;
            q1_done <= 1'b0;   q2_done <= 1'b0;
            q1_paused <= 1'b0; q2_paused <= 1'b0;
        end else begin
            hq_st <= hq_n;     lq_st <= lq_n;
            cwp <= cwp_n;      wrapped <= wrap_n;
            hq_ptr <= hq_ptr_n; lq_ptr <= lq_ptr_n; lq_wrap <= lq_wrap_n;
            q1_done <= q1_done_n; q2_done <= q2_done_n;
            q1_paused <= q1_pz_n; q2_paused <= q2_pz_n;
        end
    end

    assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hq_st == HQ_ACTIVE && lq_st == LQ_ACTIVE));

    assert_suspend_needs_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_st == LQ_SUSPEND) |-> (hq_st != HQ_IDLE));

    assert_pending_needs_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_st == LQ_PENDING) |-> (hq_st != HQ_IDLE));

    assert_cwp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !abort) |=> (cwp == (($past(cwp) == LAST_IDX) ? '0 : $past(cwp) + 1'b1)));

    assert_q1_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q1_done |-> (hq_st != HQ_ACTIVE || $past(q1_trig)));

    assert_q2_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q2_done |-> (lq_st == LQ_IDLE || $past(q2_trig)));

    assert_q1_pause_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q1_paused |-> (hq_st == HQ_PAUSED || $past(q1_trig)));

endmodule

// File: rtl/dq_cmd_sched.sv
// Module: dq_cmd_sched (top)
// Dual-queue conversion command scheduler over a shared command table.
// Assumes: the table sits outside and returns cmd_word for cwp in the same
// cycle; the converter answers each start with one conv_done pulse.
module dq_cmd_sched
    import dq_sched_pkg::*;
#(
    parameter  int TBL_DEPTH = 64,
    parameter  int CMD_W     = 16,
    parameter  int CHAN_W    = 6,
    parameter  int PAUSE_BIT = 15,
    localparam int IDX_W     = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q1_trig,
    input  logic              q2_trig,
    input  logic [IDX_W-1:0]  q2_start,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              conv_done,
    output logic [IDX_W-1:0]  cwp,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              q1_done,
    output logic              q2_done,
    output logic              q1_paused,
    output logic              q2_paused,
    output logic [1:0]        q1_status,
    output logic [2:0]        q2_status
);
    logic [CHAN_W-1:0] dec_chan;
    logic              dec_pause, end_cond;
    logic              owner_hi, wrapped, issue, abort;
    logic              busy, done_evt, cur_pause;
    hq_state_e         hq_st;
    lq_state_e         lq_st;

    dq_cmd_decode #(
        .CMD_W(CMD_W), .CHAN_W(CHAN_W), .PAUSE_BIT(PAUSE_BIT), .IDX_W(IDX_W)
    ) u_decode (
        .cmd_word(cmd_word), .cwp(cwp), .q2_start(q2_start),
        .owner_hi(owner_hi), .wrapped(wrapped),
        .chan(dec_chan), .pause(dec_pause), .end_cond(end_cond)
    );

    dq_conv_port #(.CHAN_W(CHAN_W)) u_conv (
        .clk(clk), .rst_n(rst_n), .issue(issue), .abort(abort),
        .conv_done(conv_done), .new_chan(dec_chan), .new_pause(dec_pause),
        .busy(busy), .done_evt(done_evt), .cur_pause(cur_pause),
        .conv_start(conv_start), .conv_chan(conv_chan)
    );

    dq_queue_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .q1_trig(q1_trig), .q2_trig(q2_trig),
        .q2_start(q2_start), .end_cond(end_cond), .busy(busy),
        .done_evt(done_evt), .cur_pause(cur_pause),
        .cwp(cwp), .hq_st(hq_st), .lq_st(lq_st), .owner_hi(owner_hi),
        .wrapped(wrapped), .issue(issue), .abort(abort),
        .q1_done(q1_done), .q2_done(q2_done),
        .q1_paused(q1_paused), .q2_paused(q2_paused)
    );

    // Status codes straight from the state registers.
    assign q1_status = hq_st;
    assign q2_status = lq_st;

endmodule

// File: tb/tb_dq_cmd_sched.sv
module tb_dq_cmd_sched;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, q1_trig, q2_trig, conv_done;
    logic [5:0]  q2_start;
    logic [15:0] cmd_word;
    logic [5:0]  cwp, conv_chan;
    logic conv_start, q1_done, q2_done, q1_paused, q2_paused;
    logic [1:0] q1_status;
    logic [2:0] q2_status;

    logic [15:0] tbl [64];
    int log_ch [256];
    int exp_ch [256];
    int nlog = 0, nexp = 0, exp_end = 0;
    int lat = 3, cnt = 0;
    int n_q1d = 0, n_q2d = 0, n_q1p = 0, n_q2p = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmd_word = tbl[cwp];

    dq_cmd_sched dut (
        .clk(clk), .rst_n(rst_n), .q1_trig(q1_trig), .q2_trig(q2_trig),
        .q2_start(q2_start), .cmd_word(cmd_word), .conv_done(conv_done),
        .cwp(cwp), .conv_start(conv_start), .conv_chan(conv_chan),
        .q1_done(q1_done), .q2_done(q2_done), .q1_paused(q1_paused),
        .q2_paused(q2_paused), .q1_status(q1_status), .q2_status(q2_status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Converter model and output monitor, all at the falling edge.
    initial begin
        conv_done = 1'b0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start) begin
                if (nlog < 256) log_ch[nlog] = int'(conv_chan);
                nlog++;
                cnt = lat;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) conv_done = 1'b1;
            end
            if (q1_done)   n_q1d++;
            if (q2_done)   n_q2d++;
            if (q1_paused) n_q1p++;
            if (q2_paused) n_q2p++;
        end
    end

    // Random table: channels 0..62, random don't-care bits, no pause flag.
    task automatic fill_table(input int eoq_mod);
        for (int i = 0; i < 64; i++) begin
            logic [5:0] c;
            logic [8:0] junk;
            c = 6'($urandom % 63);
            if (eoq_mod != 0 && ($urandom % eoq_mod) == 0) c = 6'd63;
            junk = 9'($urandom);
            tbl[i] = {1'b0, junk, c};
        end
    endtask

    // Expected scan from the requirements: appends channels, sets exp_end.
    task automatic build(input int start, input bit hi, input int base);
        int i = start;
        bit wr = 0;
        for (int g = 0; g < 130; g++) begin
            if (tbl[i][5:0] == 6'd63 || wr || (hi && i == base)) begin
                exp_end = i;
                return;
            end
            if (nexp < 256) exp_ch[nexp] = int'(tbl[i][5:0]);
            nexp++;
            if (tbl[i][15]) begin
                exp_end = (i == 63) ? 0 : i + 1;
                return;
            end
            if (i == 63) begin i = 0; wr = 1; end else i++;
        end
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        chk(nlog == nexp, {tag, " conversion count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog && i < 256; i++)
            if (bad < 0 && log_ch[i] != exp_ch[i]) bad = i;
        chk(bad < 0, {tag, " channel order"}, (bad < 0) ? 0 : log_ch[bad],
            (bad < 0) ? 0 : exp_ch[bad]);
    endtask

    task automatic pulse1();
        q1_trig = 1'b1; @(negedge clk); q1_trig = 1'b0;
    endtask

    task automatic pulse2();
        q2_trig = 1'b1; @(negedge clk); q2_trig = 1'b0;
    endtask

    task automatic wait_starts(input int k);
        int seen = 0;
        for (int t = 0; t < 3000 && seen < k; t++) begin
            @(negedge clk);
            if (conv_start) seen++;
        end
    endtask

    // sel: 0 q1 done, 1 q2 done, 2 q1 pause.
    task automatic wait_flag(input int sel, input string tag);
        int base = (sel == 0) ? n_q1d : (sel == 1) ? n_q2d : n_q1p;
        int now = base;
        for (int t = 0; t < 3000 && now == base; t++) begin
            @(negedge clk);
            now = (sel == 0) ? n_q1d : (sel == 1) ? n_q2d : n_q1p;
        end
        chk(now != base, {tag, " flag seen"}, 0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_logs();
        nlog = 0; nexp = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d1;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; q1_trig = 1'b0; q2_trig = 1'b0; q2_start = 6'd12;
        for (int i = 0; i < 64; i++) tbl[i] = 16'h0001;
        repeat (4) @(negedge clk);
        chk(q1_status == 2'd0 && q2_status == 3'd0, "R1 status after reset", int'(q2_status), 0);
        chk(cwp == 6'd0, "R1 cwp after reset", int'(cwp), 0);
        chk(!conv_start && !q1_done && !q2_done && !q1_paused, "R1 flags low", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Queue 1 to the queue 2 boundary, repeated q1 trigger ignored (R2 R3 R9)
        fill_table(0);
        q2_start = 6'd12; lat = 3; clear_logs(); build(0, 1, 12);
        d1 = n_q1d;
        pulse1();
        chk(q1_status == 2'd1, "R10 q1 active code", int'(q1_status), 1);
        wait_starts(2);
        pulse1();
        wait_flag(0, "R3");
        cmp_log("R2 R9 q1 scan");
        chk(cwp == 6'd12, "R3 cwp at boundary", int'(cwp), 12);
        chk(q1_status == 2'd0, "R3 q1 idle", int'(q1_status), 0);
        chk(n_q1d - d1 == 1, "R3 single-cycle done", n_q1d - d1, 1);

        // End marker inside queue 1 (R4)
        tbl[5] = 16'h7FFF;
        clear_logs(); build(0, 1, 12);
        pulse1();
        wait_flag(0, "R4");
        cmp_log("R4 q1 marker");
        chk(cwp == 6'd5, "R4 cwp on marker", int'(cwp), 5);

        // Queue 2 with marker, repeated q2 trigger ignored (R4 R9)
        fill_table(0);
        tbl[27] = {1'b0, 9'h1A5, 6'd63};
        q2_start = 6'd20; lat = 2; clear_logs(); build(20, 0, 20);
        pulse2();
        chk(q2_status == 3'd1, "R10 q2 active code", int'(q2_status), 1);
        wait_starts(3);
        pulse2();
        wait_flag(1, "R4");
        cmp_log("R4 R9 q2 scan");
        chk(cwp == 6'd27, "R4 q2 cwp on marker", int'(cwp), 27);
        chk(q2_status == 3'd0, "R4 q2 idle", int'(q2_status), 0);

        // Queue 2 wrap past entry 63 (R5)
        q2_start = 6'd60; lat = 1; clear_logs(); build(60, 0, 60);
        pulse2();
        wait_flag(1, "R5");
        cmp_log("R5 wrap scan");
        chk(cwp == 6'd0, "R5 cwp wrapped", int'(cwp), 0);

        // Pause in queue 1, queue 2 trigger while paused, resume (R6 R8)
        fill_table(0);
        tbl[4][15] = 1'b1;
        tbl[14] = 16'h003F;
        q2_start = 6'd10; lat = 3; clear_logs(); build(0, 1, 10);
        pulse1();
        wait_flag(2, "R6");
        cmp_log("R6 up to pause");
        chk(q1_status == 2'd2, "R6 q1 paused code", int'(q1_status), 2);
        chk(cwp == 6'd5, "R6 cwp after pause entry", int'(cwp), 5);
        chk(n_q1p == 1, "R6 single pause pulse", n_q1p, 1);
        pulse2();
        chk(q2_status == 3'd4, "R8 pending while q1 paused", int'(q2_status), 4);
        clear_logs(); build(5, 1, 10); build(10, 0, 10);
        pulse1();
        wait_flag(1, "R8");
        cmp_log("R6 R8 resume then pending q2");
        chk(cwp == 6'd14, "R8 q2 end pointer", int'(cwp), 14);

        // Preemption of queue 2 in flight (R7)
        fill_table(0);
        tbl[3] = 16'h003F;
        q2_start = 6'd8; lat = 4; clear_logs();
        for (int i = 8; i <= 12; i++) begin exp_ch[nexp] = int'(tbl[i][5:0]); nexp++; end
        build(0, 1, 8); build(12, 0, 8);
        pulse2();
        wait_starts(5);
        pulse1();
        chk(q2_status == 3'd3, "R7 q2 suspended code", int'(q2_status), 3);
        chk(q1_status == 2'd1, "R7 q1 active", int'(q1_status), 1);
        wait_flag(1, "R7");
        cmp_log("R7 preempt and repeat");
        chk(cwp == 6'd0, "R7 end pointer", int'(cwp), 0);

        // Queue 2 trigger while queue 1 active (R8)
        fill_table(0);
        q2_start = 6'd16; lat = 2; clear_logs(); build(0, 1, 16); build(16, 0, 16);
        pulse1();
        wait_starts(1);
        pulse2();
        chk(q2_status == 3'd4, "R8 pending code", int'(q2_status), 4);
        wait_flag(1, "R8");
        cmp_log("R8 pending then run");

        // Random tables, boundaries and latencies (R2 R3 R4 R5)
        for (int it = 0; it < 16; it++) begin
            int b;
            fill_table(6);
            b = 1 + int'($urandom % 40);
            q2_start = 6'(b); lat = 1 + int'($urandom % 5);
            clear_logs(); build(0, 1, b);
            pulse1();
            wait_flag(0, "R3 random");
            cmp_log("R2 R4 random q1");
            chk(int'(cwp) == exp_end, "R3 R4 random q1 end", int'(cwp), exp_end);
            clear_logs(); build(b, 0, b);
            pulse2();
            wait_flag(1, "R5 random");
            cmp_log("R2 R5 random q2");
            chk(int'(cwp) == exp_end, "R4 R5 random q2 end", int'(cwp), exp_end);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule